// File: doc/BRIEF.md
# Per-Pin Programmable Input Debouncer

This block filters a group of raw interrupt input pins before they reach interrupt detection. Every pin passes through a two-stage synchroniser. When its filter is active, the filtered output takes a new level only once the synchronised input has held that level for a programmed number of microsecond ticks. A pin with its filter switched off, or one marked as edge-sensitive, passes the synchronised level straight through.

Software programs each pin through an 8-bit control field, and four of these fields share one 32-bit word. There are three windows on a simple word-wide bus. A read window returns the stored fields. A write-one-to-set window ORs bits into a field, and a write-one-to-clear window removes them. To reprogram a pin, software first clears its whole field and then sets the enable bit, the new time index and the counter-reset bit in one write. Software also writes the counter-reset bit after it services an event on a debounced pin. That bit never stays in the field: it restarts the pin's counter on the following clock.

Top module: `dbnc_bank`

## Requirements
- R1: After reset every field reads 0, so every filter is off and every filtered output is 0.
- R2: Pin n owns byte (n mod 4) of word n/4. In that byte, bit 0 is the enable, bit 1 is the counter reset, bits 3:2 are unused and always read 0, and bits 7:4 hold the time index.
- R3: Word k of the read window is at 0x500+4k, of the set window at 0x600+4k and of the clear window at 0x700+4k. A set write ORs the written enable and index bits into each field, and a clear write removes them. A write to the read window changes nothing. A read from any other address returns 0.
- R4: A pin whose enable is 0 drives its output from the synchronised input, which is the raw input delayed by two clock edges. The output register adds one more edge.
- R5: A pin whose sensitivity input is 0 (edge-sensitive) bypasses the filter the same way, whatever its enable is.
- R6: With the filter active, the output takes the synchronised level on the tick in which that level has differed from the output for T consecutive ticks. Clock cycles without a tick do not count. T depends on the index: 0:125, 1:250, 2:500, 3:1000, 4:16000, 5:32000, 6:64000, 7:128000, 8:256000, 9:512000.
- R7: If the synchronised input returns to the output level before T ticks have passed, the output does not change and the count starts again from zero.
- R8: An index from 10 to 15 uses the largest threshold, 512000 ticks.
- R9: Writing 1 to the counter-reset bit through the set window zeroes that pin's count on the next clock and leaves the output unchanged. The bit always reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the set and clear windows |
| bus_addr | input | 12 | Byte address of the word being accessed |
| bus_wdata | input | 32 | Write data, four 8-bit pin fields |
| bus_rdata | output | 32 | Read data from the read window, otherwise 0 |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| pin_raw | input | 8 | Raw asynchronous pin levels |
| pin_level | input | 8 | Per-pin sensitivity: 1 level (filtered), 0 edge (bypass) |
| pin_filt | output | 8 | Filtered pin levels |

## Verification
The hardest case to reach is a counter reset that lands in the middle of a count, because the effect shows only as a filtered edge arriving later than it otherwise would. The stimulus drives a pin to a new level and lets about 100 of its 125 ticks pass. It then writes only the reset bit through the set window and checks that the output is still unchanged where the uninterrupted count would have ended, and that it changes one full threshold later. The bench also slows the tick to every second cycle so that a 250-tick threshold can be seen not to count bare clock cycles. A reference model checks the whole output vector and the read data on every clock.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    localparam int FIELD_W       = 8;
    localparam int PINS_PER_WORD = 4;
    localparam int IDX_W         = 4;
    localparam int CNT_W         = 19;

    // Per-pin control byte; bit 0 enable, bit 1 counter restart, bits 7:4 index.
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [1:0]       unused;
        logic             restart;
        logic             en;
    } pin_field_t;

    // Threshold in microsecond ticks for a time index; large indices saturate.
    function automatic logic [CNT_W-1:0] ticks_for(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    ticks_for = CNT_W'(125);
            4'd1:    ticks_for = CNT_W'(250);
            4'd2:    ticks_for = CNT_W'(500);
            4'd3:    ticks_for = CNT_W'(1000);
            4'd4:    ticks_for = CNT_W'(16000);
            4'd5:    ticks_for = CNT_W'(32000);
            4'd6:    ticks_for = CNT_W'(64000);
            4'd7:    ticks_for = CNT_W'(128000);
            4'd8:    ticks_for = CNT_W'(256000);
            default: ticks_for = CNT_W'(512000);
        endcase
    endfunction

endpackage

// File: rtl/dbnc_regs.sv
module dbnc_regs
    import dbnc_pkg::*;
#(
    parameter int                NUM_PINS  = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h500,
    parameter logic [ADDR_W-1:0] SET_BASE  = 12'h600,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 12'h700
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [NUM_PINS-1:0]       cfg_en,
    output logic [NUM_PINS*IDX_W-1:0] cfg_idx,
    output logic [NUM_PINS-1:0]       cnt_restart
);

    localparam int                WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(WORDS * 4);

    logic [ADDR_W-1:0] offs_set, offs_clr, offs_rd;
    logic              hit_set, hit_clr, hit_rd;
    logic [FIELD_W-1:0] lane_v [NUM_PINS];

    assign offs_set = bus_addr - SET_BASE;
    assign offs_clr = bus_addr - CLR_BASE;
    assign offs_rd  = bus_addr - CTRL_BASE;

    assign hit_set = bus_wr && (bus_addr >= SET_BASE) && (offs_set < SPAN) && (offs_set[1:0] == 2'b00);
    assign hit_clr = bus_wr && (bus_addr >= CLR_BASE) && (offs_clr < SPAN) && (offs_clr[1:0] == 2'b00);
    assign hit_rd  = (bus_addr >= CTRL_BASE) && (offs_rd < SPAN) && (offs_rd[1:0] == 2'b00);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
        localparam int WD = p / PINS_PER_WORD;
        localparam int LN = p % PINS_PER_WORD;

        pin_field_t fld_q;
        pin_field_t wr_f;
        logic       sel_set, sel_clr;

        assign wr_f    = pin_field_t'(bus_wdata[LN*FIELD_W +: FIELD_W]);
        assign sel_set = hit_set && (offs_set[ADDR_W-1:2] == (ADDR_W-2)'(WD));
        assign sel_clr = hit_clr && (offs_clr[ADDR_W-1:2] == (ADDR_W-2)'(WD));

        always_ff @(posedge clk) begin
            if (rst) begin
                fld_q          <= '0;
                cnt_restart[p] <= 1'b0;
            end else begin
                cnt_restart[p] <= sel_set && wr_f.restart;
                if (sel_set) begin
                    fld_q.en  <= fld_q.en | wr_f.en;
                    fld_q.idx <= fld_q.idx | wr_f.idx;
                end else if (sel_clr) begin
                    fld_q.en  <= fld_q.en & ~wr_f.en;
                    fld_q.idx <= fld_q.idx & ~wr_f.idx;
                end
            end
        end

        assign cfg_en[p]                 = fld_q.en;
        assign cfg_idx[p*IDX_W +: IDX_W] = fld_q.idx;
        assign lane_v[p]                 = {fld_q.idx, 3'b000, fld_q.en};
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_rd) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (int'(offs_rd[ADDR_W-1:2]) == p / PINS_PER_WORD)
                    bus_rdata[(p % PINS_PER_WORD)*FIELD_W +: FIELD_W] = lane_v[p];
            end
        end
    end

endmodule

// File: rtl/dbnc_pin.sv
module dbnc_pin
    import dbnc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_in,
    input  logic             level_mode,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic             tick,
    input  logic             restart,
    output logic             filt_out
);

    logic             s1_q, s2_q, filt_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W:0]   cnt_nxt;
    logic             act;

    assign act      = en && level_mode;
    assign thr      = ticks_for(idx);
    assign cnt_nxt  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign filt_out = filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            s1_q <= raw_in;
            s2_q <= s1_q;
            if (!act) begin
                filt_q <= s2_q;
                cnt_q  <= '0;
            end else if (restart || (s2_q == filt_q)) begin
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_nxt >= {1'b0, thr}) begin
                    filt_q <= s2_q;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_nxt[CNT_W-1:0];
                end
            end
        end
    end

    a_r9_cnt_zeroed: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));

    a_r9_out_held: assert property (@(posedge clk) disable iff (rst)
        (act && restart) |=> $stable(filt_q));

    a_r7_hold_when_equal: assert property (@(posedge clk) disable iff (rst)
        (act && (s2_q == filt_q)) |=> $stable(filt_q));

    a_r6_tick_only: assert property (@(posedge clk) disable iff (rst)
        (act && !tick) |=> $stable(filt_q));

endmodule

// File: rtl/dbnc_bank.sv
module dbnc_bank
    import dbnc_pkg::*;
#(
    parameter int                NUM_PINS  = 8,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h500,
    parameter logic [ADDR_W-1:0] SET_BASE  = 12'h600,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 12'h700
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                tick_us,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] pin_level,
    output logic [NUM_PINS-1:0] pin_filt
);

    logic [NUM_PINS-1:0]       cfg_en;
    logic [NUM_PINS*IDX_W-1:0] cfg_idx;
    logic [NUM_PINS-1:0]       cnt_restart;

    dbnc_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .CTRL_BASE(CTRL_BASE),
        .SET_BASE (SET_BASE),
        .CLR_BASE (CLR_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cfg_en     (cfg_en),
        .cfg_idx    (cfg_idx),
        .cnt_restart(cnt_restart)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        dbnc_pin u_pin (
            .clk       (clk),
            .rst       (rst),
            .raw_in    (pin_raw[p]),
            .level_mode(pin_level[p]),
            .en        (cfg_en[p]),
            .idx       (cfg_idx[p*IDX_W +: IDX_W]),
            .tick      (tick_us),
            .restart   (cnt_restart[p]),
            .filt_out  (pin_filt[p])
        );
    end

endmodule

// File: tb/test_dbnc_bank.sv
module test_dbnc_bank;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_us = 1'b0;
    logic [N-1:0] pin_raw = '0;
    logic [N-1:0] pin_level = '1;
    logic [N-1:0] pin_filt;

    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    int    tick_div = 1;
    int    tick_cnt = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #4 clk = ~clk;

    dbnc_bank i_dbnc_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_us(tick_us),
        .pin_raw(pin_raw), .pin_level(pin_level), .pin_filt(pin_filt)
    );

    // Reference model
    int thr_tab [10] = '{125, 250, 500, 1000, 16000, 32000, 64000, 128000, 256000, 512000};
    bit m_s1 [N];
    bit m_s2 [N];
    bit m_f  [N];
    int m_cnt [N];
    bit m_en [N];
    bit [3:0] m_idx [N];
    bit m_pend [N];

    function automatic int thr_of(bit [3:0] i);
        return (i >= 10) ? 512000 : thr_tab[i];
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        int a = int'(bus_addr);
        if (a >= 'h500 && a < 'h508 && a[1:0] == 2'b00) begin
            for (int p = 0; p < N; p++)
                if ((a - 'h500) / 4 == p / 4)
                    v[(p % 4)*8 +: 8] = {m_idx[p], 3'b000, m_en[p]};
        end
        return v;
    endfunction

    function automatic logic [N-1:0] exp_filt();
        logic [N-1:0] v;
        for (int p = 0; p < N; p++) v[p] = m_f[p];
        return v;
    endfunction

    always @(posedge clk) begin
        tick_cnt <= tick_cnt + 1;
        tick_us  <= #1 (((tick_cnt + 1) % tick_div) == 0);
    end

    always @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (rst) begin
                m_s1[p] <= 0; m_s2[p] <= 0; m_f[p] <= 0; m_cnt[p] <= 0;
                m_en[p] <= 0; m_idx[p] <= 0; m_pend[p] <= 0;
            end else begin
                bit [7:0] b;
                b = bus_wdata[(p % 4)*8 +: 8];
                m_s1[p] <= pin_raw[p];
                m_s2[p] <= m_s1[p];
                if (!(m_en[p] && pin_level[p])) begin
                    m_f[p] <= m_s2[p];
                    m_cnt[p] <= 0;
                end else if (m_pend[p] || m_s2[p] == m_f[p]) begin
                    m_cnt[p] <= 0;
                end else if (tick_us) begin
                    if (m_cnt[p] + 1 >= thr_of(m_idx[p])) begin
                        m_f[p] <= m_s2[p];
                        m_cnt[p] <= 0;
                    end else begin
                        m_cnt[p] <= m_cnt[p] + 1;
                    end
                end
                m_pend[p] <= 0;
                if (bus_wr && int'(bus_addr) == 'h600 + 4*(p/4)) begin
                    if (b[0]) m_en[p] <= 1;
                    m_idx[p] <= m_idx[p] | b[7:4];
                    m_pend[p] <= b[1];
                end else if (bus_wr && int'(bus_addr) == 'h700 + 4*(p/4)) begin
                    if (b[0]) m_en[p] <= 0;
                    m_idx[p] <= m_idx[p] & ~b[7:4];
                end
            end
        end
    end

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            compared++;
            if (pin_filt !== exp_filt() || bus_rdata !== exp_rd()) begin
                mismatched++;
                $display("FAIL %s cycle %0d: filt=%h exp %h rdata=%h exp %h",
                         cur_req, cycles, pin_filt, exp_filt(), bus_rdata, exp_rd());
            end
        end
    end

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
        bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        @(posedge clk); #1;
        bus_addr = '0;
    endtask

    task automatic chk_pin(int p, bit exp, string req);
        @(negedge clk);
        chk(req, 32'(pin_filt[p]), 32'(exp));
    endtask

    initial begin
        cyc(5);
        rst = 0;
        cur_req = "R1";
        @(negedge clk);
        chk("R1 outputs", 32'(pin_filt), 32'h0);
        rd(12'h500, 32'h0, "R1 word0");
        rd(12'h504, 32'h0, "R1 word1");

        // R4: filter off, output follows input after sync
        cur_req = "R4";
        pin_raw = 8'hA5;
        cyc(3);
        chk_pin(0, 1'b1, "R4 pin0 passthrough");
        chk("R4 all pins", 32'(pin_filt), 32'hA5);

        // R2 / R3: field packing and windows
        cur_req = "R2";
        wr(12'h600, 32'h20A1_1101);
        rd(12'h500, 32'h20A1_1101, "R2 word0 readback");
        wr(12'h604, 32'h0000_000C);
        rd(12'h504, 32'h0, "R2 unused bits read 0");
        cur_req = "R3";
        wr(12'h500, 32'hFFFF_FFFF);
        rd(12'h500, 32'h20A1_1101, "R3 read window write ignored");
        wr(12'h700, 32'h0000_0100);
        rd(12'h500, 32'h20A1_1001, "R3 clear pin1 enable");
        wr(12'h600, 32'h0000_0100);
        rd(12'h500, 32'h20A1_1101, "R3 set pin1 enable");
        rd(12'h508, 32'h0, "R3 outside window");

        // R6: pin0, 125 ticks, tick every cycle
        cur_req = "R6";
        pin_raw[0] = 1'b0;
        cyc(100);
        chk_pin(0, 1'b1, "R6 pin0 before threshold");
        cyc(40);
        chk_pin(0, 1'b0, "R6 pin0 after 125 ticks");

        // R6: pin1, 250 ticks, tick every second cycle
        tick_div = 2;
        pin_raw[1] = 1'b1;
        cyc(450);
        chk_pin(1, 1'b0, "R6 pin1 cycles without tick not counted");
        cyc(100);
        chk_pin(1, 1'b1, "R6 pin1 after 250 ticks");
        tick_div = 1;

        // R7: glitch shorter than threshold
        cur_req = "R7";
        pin_raw[0] = 1'b1;
        cyc(60);
        pin_raw[0] = 1'b0;
        cyc(200);
        chk_pin(0, 1'b0, "R7 short pulse rejected");

        // R8: index 10 saturates to 512000
        cur_req = "R8";
        pin_raw[2] = 1'b0;
        cyc(2000);
        chk_pin(2, 1'b1, "R8 saturated index holds");

        // R9: counter restart in mid-count
        cur_req = "R9";
        pin_raw[0] = 1'b1;
        cyc(100);
        wr(12'h600, 32'h0000_0002);
        rd(12'h500, 32'h20A1_1101, "R9 restart bit reads 0");
        cyc(100);
        chk_pin(0, 1'b0, "R9 output held after restart");
        cyc(40);
        chk_pin(0, 1'b1, "R9 output after full threshold");

        // R5: edge-sensitive pin bypasses filter
        cur_req = "R5";
        pin_level[0] = 1'b0;
        pin_raw[0] = 1'b0;
        cyc(4);
        chk_pin(0, 1'b0, "R5 bypass despite enable");

        cyc(5);
        summary();
    end

endmodule